// File: doc/BRIEF.md
# Integer ALU with Flag Generation

This block is the integer execution stage of a small RISC core. Each cycle it takes two 32-bit operands and an operation code and returns one result. Its arithmetic adds, bitwise logic, shifts, immediate placement, width extensions, conditional select and lowest-set-bit search are all combinational. It also computes new values for two one-bit flags: a carry flag and a condition flag. Compare operations produce no data and only decide the condition flag. Conditional select reads that flag, and add-with-carry reads the carry flag.

The two flags sit in a small register stage inside the top module, so a sequence of operations can be exercised on its own. A flag register loads only in a cycle where `op_valid` is high. The result output is combinational: it uses the operands, the op code and the flags stored at that moment. A parameter selects whether add, add-with-carry and AND also report a zero result on the condition flag.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst_n` is low, both `carry_q` and `flag_q` are cleared to 0.
- R2: Op 0 (add) gives `opnd_a + opnd_b` modulo 2^32. Op 1 (add-with-carry) gives the same sum plus one when `carry_q` is 1.
- R3: On a valid op 0 or op 1, `carry_q` loads 1 when the 32-bit result is unsigned-less-than `opnd_a`, and loads 0 otherwise.
- R4: With `ARITH_FLAG_EN`=1, a valid op 0, 1 or 3 loads `flag_q` with 1 for a zero result and 0 otherwise. With `ARITH_FLAG_EN`=0 these ops leave `flag_q` unchanged.
- R5: Op 2 gives `opnd_a - opnd_b`. Op 3 gives the bitwise AND, op 4 the OR and op 5 the XOR of the operands.
- R6: Op 6 shifts `opnd_a` left, op 7 shifts it right with zero fill, and op 8 shifts it right filling with bit 31. The shift amount is `opnd_b[4:0]`; higher bits of `opnd_b` are ignored.
- R7: Op 9 gives `{opnd_b[15:0], 16'h0000}`.
- R8: Ops 10 and 11 sign- and zero-extend `opnd_a[7:0]`. Ops 12 and 13 do the same for `opnd_a[15:0]`. Ops 14 and 15 do the same for `opnd_a[31:0]`, which at 32 bits returns the operand unchanged.
- R9: Ops 18 to 27 are compares and give result 0. They load `flag_q` with the truth of: 18 a==b, 19 a!=b, 20 a>b signed, 21 a>=b signed, 22 a<b signed, 23 a<=b signed, 24 a>b unsigned, 25 a>=b unsigned, 26 a<b unsigned, 27 a<=b unsigned.
- R10: Op 16 gives `opnd_a` when `flag_q` is 1 and `opnd_b` when it is 0.
- R11: Op 17 gives the 1-based index of the lowest set bit of `opnd_a`, or 0 when `opnd_a` is zero.
- R12: When `op_valid` is low, both flags keep their value. Ops that R3, R4 and R9 do not name also keep both flags.
- R13: Op codes 28 to 31 give result 0 and keep both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag registers |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| op_valid | input | 1 | Allows the flags to load this cycle |
| op_code | input | 5 | Operation select, encodings listed in the requirements |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand; also supplies the shift amount and the immediate |
| result | output | 32 | Combinational result |
| carry_q | output | 1 | Stored carry flag |
| flag_q | output | 1 | Stored condition flag |

## Verification
The bench builds the unit twice at the default 32-bit width. One instance has `ARITH_FLAG_EN`=1 and runs the full vector table. The other has `ARITH_FLAG_EN`=0, which exposes the case where add and AND must leave the condition flag alone. The 32-bit width lets the vectors reach the shift-amount wrap at 32, sign fill from bit 31, and the highest lowest-set-bit index of 32. It also reaches the add-with-carry case where a full-ones second operand wraps the sum back to the first operand and clears the carry.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADDC  = 5'd1,
        OP_SUB   = 5'd2,
        OP_AND   = 5'd3,
        OP_OR    = 5'd4,
        OP_XOR   = 5'd5,
        OP_SLL   = 5'd6,
        OP_SRL   = 5'd7,
        OP_SRA   = 5'd8,
        OP_LDHI  = 5'd9,
        OP_EXBS  = 5'd10,
        OP_EXBZ  = 5'd11,
        OP_EXHS  = 5'd12,
        OP_EXHZ  = 5'd13,
        OP_EXWS  = 5'd14,
        OP_EXWZ  = 5'd15,
        OP_CMOV  = 5'd16,
        OP_FFS   = 5'd17,
        OP_SFEQ  = 5'd18,
        OP_SFNE  = 5'd19,
        OP_SFGTS = 5'd20,
        OP_SFGES = 5'd21,
        OP_SFLTS = 5'd22,
        OP_SFLES = 5'd23,
        OP_SFGTU = 5'd24,
        OP_SFGEU = 5'd25,
        OP_SFLTU = 5'd26,
        OP_SFLEU = 5'd27
    } iexu_op_e;

    typedef enum logic [2:0] {
        CMP_EQ = 3'd0,
        CMP_NE = 3'd1,
        CMP_GT = 3'd2,
        CMP_GE = 3'd3,
        CMP_LT = 3'd4,
        CMP_LE = 3'd5
    } cmp_kind_e;

    typedef struct packed {
        cmp_kind_e kind;
        logic      signed_cmp;
        logic      is_cmp;
    } cmp_ctl_t;

endpackage

// File: rtl/iexu_lowbit.sv
module iexu_lowbit #(
    parameter int W = 32,
    localparam int PW = $clog2(W + 1)
) (
    input  logic [W-1:0]  val,
    output logic [PW-1:0] pos
);
    // Scan from the top so that the lowest set bit is written last and wins.
    always_comb begin
        pos = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (val[i]) begin
                pos = PW'(i + 1);
            end
        end
    end
endmodule

// File: rtl/iexu_compare.sv
module iexu_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0]        lhs,
    input  logic [W-1:0]        rhs,
    input  iexu_pkg::cmp_ctl_t  ctl,
    output logic                hit
);
    import iexu_pkg::*;

    logic eq, lt;

    always_comb begin
        eq = (lhs == rhs);
        lt = ctl.signed_cmp ? ($signed(lhs) < $signed(rhs)) : (lhs < rhs);
        hit = 1'b0;
        if (ctl.is_cmp) begin
            unique case (ctl.kind)
                CMP_EQ:  hit = eq;
                CMP_NE:  hit = !eq;
                CMP_GT:  hit = !lt && !eq;
                CMP_GE:  hit = !lt;
                CMP_LT:  hit = lt;
                CMP_LE:  hit = lt || eq;
                default: hit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/iexu_datapath.sv
module iexu_datapath #(
    parameter int W             = 32,
    parameter bit ARITH_FLAG_EN = 1'b1
) (
    input  iexu_pkg::iexu_op_e op,
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    input  logic               carry_in,
    input  logic               flag_in,
    output logic [W-1:0]       res,
    output logic               carry_nx,
    output logic               flag_nx
);
    import iexu_pkg::*;

    localparam int SHW = $clog2(W);
    localparam int PW  = $clog2(W + 1);

    logic [W-1:0]   sum;
    logic [SHW-1:0] shamt;
    logic [PW-1:0]  low_pos;
    logic [W-1:0]   ext_ws, ext_wz;
    cmp_ctl_t       cctl;
    logic           cmp_hit;
    logic           is_add;

    assign is_add = (op == OP_ADD) || (op == OP_ADDC);
    assign sum    = a + b + {{(W-1){1'b0}}, (op == OP_ADDC) && carry_in};
    assign shamt  = b[SHW-1:0];

    // Word extension only changes the value when the datapath is wider than a word.
    generate
        if (W > 32) begin : g_wide
            assign ext_ws = {{(W-32){a[31]}}, a[31:0]};
            assign ext_wz = {{(W-32){1'b0}}, a[31:0]};
        end else begin : g_word
            assign ext_ws = a;
            assign ext_wz = a;
        end
    endgenerate

    always_comb begin
        cctl = '{kind: CMP_EQ, signed_cmp: 1'b0, is_cmp: 1'b1};
        unique case (op)
            OP_SFEQ:  cctl.kind = CMP_EQ;
            OP_SFNE:  cctl.kind = CMP_NE;
            OP_SFGTS: begin cctl.kind = CMP_GT; cctl.signed_cmp = 1'b1; end
            OP_SFGES: begin cctl.kind = CMP_GE; cctl.signed_cmp = 1'b1; end
            OP_SFLTS: begin cctl.kind = CMP_LT; cctl.signed_cmp = 1'b1; end
            OP_SFLES: begin cctl.kind = CMP_LE; cctl.signed_cmp = 1'b1; end
            OP_SFGTU: cctl.kind = CMP_GT;
            OP_SFGEU: cctl.kind = CMP_GE;
            OP_SFLTU: cctl.kind = CMP_LT;
            OP_SFLEU: cctl.kind = CMP_LE;
            default:  cctl.is_cmp = 1'b0;
        endcase
    end

    iexu_compare #(.W(W)) u_cmp (
        .lhs (a),
        .rhs (b),
        .ctl (cctl),
        .hit (cmp_hit)
    );

    iexu_lowbit #(.W(W)) u_lowbit (
        .val (a),
        .pos (low_pos)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_ADDC: res = sum;
            OP_SUB:  res = a - b;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_SLL:  res = a << shamt;
            OP_SRL:  res = a >> shamt;
            OP_SRA:  res = $unsigned($signed(a) >>> shamt);
            OP_LDHI: res = W'(b[15:0]) << 16;
            OP_EXBS: res = {{(W-8){a[7]}}, a[7:0]};
            OP_EXBZ: res = {{(W-8){1'b0}}, a[7:0]};
            OP_EXHS: res = {{(W-16){a[15]}}, a[15:0]};
            OP_EXHZ: res = {{(W-16){1'b0}}, a[15:0]};
            OP_EXWS: res = ext_ws;
            OP_EXWZ: res = ext_wz;
            OP_CMOV: res = flag_in ? a : b;
            OP_FFS:  res = W'(low_pos);
            default: res = '0;
        endcase
    end

    always_comb begin
        carry_nx = carry_in;
        flag_nx  = flag_in;
        if (is_add) begin
            carry_nx = (sum < a);
        end
        if (ARITH_FLAG_EN && (is_add || op == OP_AND)) begin
            flag_nx = (res == '0);
        end
        if (cctl.is_cmp) begin
            flag_nx = cmp_hit;
        end
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
    parameter int XLEN          = 32,
    parameter bit ARITH_FLAG_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [4:0]      op_code,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output logic [XLEN-1:0] result,
    output logic            carry_q,
    output logic            flag_q
);
    import iexu_pkg::*;

    logic carry_nx, flag_nx;

    iexu_datapath #(.W(XLEN), .ARITH_FLAG_EN(ARITH_FLAG_EN)) u_dp (
        .op       (iexu_op_e'(op_code)),
        .a        (opnd_a),
        .b        (opnd_b),
        .carry_in (carry_q),
        .flag_in  (flag_q),
        .res      (result),
        .carry_nx (carry_nx),
        .flag_nx  (flag_nx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            flag_q  <= 1'b0;
        end else if (op_valid) begin
            carry_q <= carry_nx;
            flag_q  <= flag_nx;
        end
    end
endmodule

// File: rtl/int_exec_unit_sva.sv
module int_exec_unit_sva #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [4:0]   op_code,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] result,
    input logic         carry_q,
    input logic         flag_q
);
    import iexu_pkg::*;

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(carry_q) && $stable(flag_q)));

    assert_add_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ADD) |=> (carry_q == ($past(result) < $past(opnd_a))));

    assert_cmp_eq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_SFEQ) |=> (flag_q == ($past(opnd_a) == $past(opnd_b))));

    assert_cmov_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_CMOV) |-> (result == (flag_q ? opnd_a : opnd_b)));

    assert_ldhi_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_LDHI) |-> (result[15:0] == 16'h0000 && result[31:16] == opnd_b[15:0]));

    assert_ffs_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == OP_FFS && opnd_a == '0) |-> (result == '0));

    assert_undef_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code >= 5'd28) |-> (result == '0));

    assert_logic_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_OR || op_code == OP_XOR || op_code == OP_SUB))
        |=> ($stable(carry_q) && $stable(flag_q)));
endmodule

bind int_exec_unit int_exec_unit_sva #(.W(XLEN)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .result   (result),
    .carry_q  (carry_q),
    .flag_q   (flag_q)
);

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct packed {
        logic [3:0]  rq;
        logic [4:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic        c;
        logic        f;
    } vec_t;

    localparam int NV = 37;
    // Expected flags are the values after the vector's clock edge; flags carry across rows.
    localparam vec_t VECS [NV] = '{
        '{4'd2,  5'd0,  32'h00000001, 32'h00000002, 32'h00000003, 1'b0, 1'b0}, // R2
        '{4'd3,  5'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b1}, // R3 R4
        '{4'd2,  5'd1,  32'h00000005, 32'h00000007, 32'h0000000D, 1'b0, 1'b0}, // R2 carry in
        '{4'd3,  5'd0,  32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b1}, // R3
        '{4'd3,  5'd1,  32'h00000005, 32'hFFFFFFFF, 32'h00000005, 1'b0, 1'b0}, // R3 wrap to a
        '{4'd5,  5'd2,  32'h0000000A, 32'h00000003, 32'h00000007, 1'b0, 1'b0}, // R5
        '{4'd4,  5'd3,  32'hF0F0F0F0, 32'h0F0F0F0F, 32'h00000000, 1'b0, 1'b1}, // R4 and
        '{4'd10, 5'd16, 32'h0000AAAA, 32'h00005555, 32'h0000AAAA, 1'b0, 1'b1}, // R10
        '{4'd5,  5'd4,  32'hF0000000, 32'h0000000F, 32'hF000000F, 1'b0, 1'b1}, // R5
        '{4'd5,  5'd5,  32'hFFFF0000, 32'hFF00FF00, 32'h00FFFF00, 1'b0, 1'b1}, // R5
        '{4'd9,  5'd18, 32'h00000007, 32'h00000007, 32'h00000000, 1'b0, 1'b1}, // R9
        '{4'd9,  5'd19, 32'h00000007, 32'h00000007, 32'h00000000, 1'b0, 1'b0}, // R9
        '{4'd10, 5'd16, 32'h0000AAAA, 32'h00005555, 32'h00005555, 1'b0, 1'b0}, // R10
        '{4'd9,  5'd20, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 1'b0}, // R9
        '{4'd9,  5'd24, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 1'b1}, // R9
        '{4'd9,  5'd22, 32'h80000000, 32'h7FFFFFFF, 32'h00000000, 1'b0, 1'b1}, // R9
        '{4'd9,  5'd26, 32'h80000000, 32'h7FFFFFFF, 32'h00000000, 1'b0, 1'b0}, // R9
        '{4'd9,  5'd21, 32'h00000003, 32'h00000003, 32'h00000000, 1'b0, 1'b1}, // R9
        '{4'd9,  5'd23, 32'h00000004, 32'h00000003, 32'h00000000, 1'b0, 1'b0}, // R9
        '{4'd9,  5'd25, 32'h00000002, 32'h00000003, 32'h00000000, 1'b0, 1'b0}, // R9
        '{4'd9,  5'd27, 32'h00000003, 32'h00000003, 32'h00000000, 1'b0, 1'b1}, // R9
        '{4'd6,  5'd6,  32'h00000001, 32'h00000023, 32'h00000008, 1'b0, 1'b1}, // R6
        '{4'd6,  5'd7,  32'h80000000, 32'h0000001F, 32'h00000001, 1'b0, 1'b1}, // R6
        '{4'd6,  5'd8,  32'h80000000, 32'h00000004, 32'hF8000000, 1'b0, 1'b1}, // R6
        '{4'd6,  5'd8,  32'h40000000, 32'h00000021, 32'h20000000, 1'b0, 1'b1}, // R6
        '{4'd7,  5'd9,  32'h12345678, 32'hABCD1234, 32'h12340000, 1'b0, 1'b1}, // R7
        '{4'd8,  5'd10, 32'h00000080, 32'h00000000, 32'hFFFFFF80, 1'b0, 1'b1}, // R8
        '{4'd8,  5'd11, 32'hFFFFFF80, 32'h00000000, 32'h00000080, 1'b0, 1'b1}, // R8
        '{4'd8,  5'd12, 32'h00018000, 32'h00000000, 32'hFFFF8000, 1'b0, 1'b1}, // R8
        '{4'd8,  5'd13, 32'hFFFF8001, 32'h00000000, 32'h00008001, 1'b0, 1'b1}, // R8
        '{4'd8,  5'd14, 32'h87654321, 32'h00000000, 32'h87654321, 1'b0, 1'b1}, // R8
        '{4'd8,  5'd15, 32'h87654321, 32'h00000000, 32'h87654321, 1'b0, 1'b1}, // R8
        '{4'd11, 5'd17, 32'h00000000, 32'h00000000, 32'h00000000, 1'b0, 1'b1}, // R11
        '{4'd11, 5'd17, 32'h00000100, 32'h00000000, 32'h00000009, 1'b0, 1'b1}, // R11
        '{4'd11, 5'd17, 32'h80000000, 32'h00000000, 32'h00000020, 1'b0, 1'b1}, // R11
        '{4'd11, 5'd17, 32'hFFFFFFFF, 32'h00000000, 32'h00000001, 1'b0, 1'b1}, // R11
        '{4'd13, 5'd31, 32'h00001234, 32'h00005678, 32'h00000000, 1'b0, 1'b1}  // R13
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid, nf_valid;
    logic [4:0]  op_code;
    logic [31:0] opnd_a, opnd_b;
    logic [31:0] result, nf_result;
    logic        carry_q, flag_q, nf_carry, nf_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    int_exec_unit #(.XLEN(32), .ARITH_FLAG_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .carry_q(carry_q), .flag_q(flag_q)
    );

    int_exec_unit #(.XLEN(32), .ARITH_FLAG_EN(1'b0)) uut_nf (
        .clk(clk), .rst_n(rst_n), .op_valid(nf_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(nf_result),
        .carry_q(nf_carry), .flag_q(nf_flag)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [4:0] op, input logic [31:0] a,
                         input logic [31:0] b);
        @(negedge clk);
        op_valid = v;
        op_code  = op;
        opnd_a   = a;
        opnd_b   = b;
        #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; nf_valid = 1'b0;
        op_code = 5'd0; opnd_a = '0; opnd_b = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 carry after reset", {31'b0, carry_q}, 32'd0);
        chk("R1 flag after reset", {31'b0, flag_q}, 32'd0);
        chk("R1 second unit flags", {30'b0, nf_carry, nf_flag}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].op, VECS[i].a, VECS[i].b);
            chk($sformatf("R%0d result row %0d", VECS[i].rq, i), result, VECS[i].res);
            @(posedge clk);
            #1;
            chk($sformatf("R%0d carry row %0d", VECS[i].rq, i), {31'b0, carry_q}, {31'b0, VECS[i].c});
            chk($sformatf("R%0d flag row %0d", VECS[i].rq, i), {31'b0, flag_q}, {31'b0, VECS[i].f});
        end

        // R12: an idle cycle with a carry-producing add leaves both flags (c0 f1).
        drive(1'b0, 5'd0, 32'hFFFFFFFF, 32'h00000001);
        chk("R2 idle add result", result, 32'h0);
        @(posedge clk); #1;
        chk("R12 idle carry held", {31'b0, carry_q}, 32'd0);
        chk("R12 idle flag held", {31'b0, flag_q}, 32'd1);

        // R4: second unit has the zero-result flag option off.
        nf_valid = 1'b1;
        drive(1'b1, 5'd0, 32'hFFFFFFFF, 32'h00000001);
        @(posedge clk); #1;
        chk("R3 carry set", {31'b0, carry_q}, 32'd1);
        chk("R3 option off carry set", {31'b0, nf_carry}, 32'd1);
        chk("R4 option off flag held on add", {31'b0, nf_flag}, 32'd0);

        drive(1'b1, 5'd3, 32'h00000000, 32'h00000005);
        chk("R5 and result", result, 32'h0);
        @(posedge clk); #1;
        chk("R12 and keeps carry", {31'b0, carry_q}, 32'd1);
        chk("R4 and sets flag", {31'b0, flag_q}, 32'd1);
        chk("R4 option off flag held on and", {31'b0, nf_flag}, 32'd0);

        // R2: stored carry feeds add-with-carry of zeros.
        drive(1'b1, 5'd1, 32'h00000000, 32'h00000000);
        chk("R2 addc uses stored carry", result, 32'h1);
        chk("R2 option off addc", nf_result, 32'h1);
        @(posedge clk); #1;
        chk("R3 addc carry clear", {31'b0, carry_q}, 32'd0);
        chk("R4 addc nonzero flag", {31'b0, flag_q}, 32'd0);
        nf_valid = 1'b0;

        // R1: reset clears flags set mid-run.
        drive(1'b1, 5'd0, 32'hFFFFFFFF, 32'h00000001);
        @(posedge clk); #1;
        @(negedge clk);
        rst_n = 1'b0;
        op_valid = 1'b0;
        @(posedge clk); #1;
        chk("R1 mid-run reset", {30'b0, carry_q, flag_q}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        summary();
    end
endmodule